// File: doc/BRIEF.md
# Two-Port Load-Linked / Store-Conditional Synchronization Unit

This unit gives two concurrent requesters, called port A and port B, atomic read-modify-write access to a shared word memory. It owns a dual-ported memory model. Each port can issue a plain read, a plain write, a load-linked or a store-conditional.

A load-linked returns a word and places a reservation on its address. A later store-conditional from the same port writes only if that reservation is still intact. Every store-conditional reports pass or fail to the requester. Requesters build test-and-set locks on this pair, and they retry after a failed store-conditional themselves.

The unit also keeps the two ports off the same memory word in the same cycle. Port A has fixed priority. When both ports present the same address, port B is stalled and must hold its request.

Top module: `llsc_sync_unit`

## Requirements
- R1: Operation codes on `a_op`/`b_op` are 2'b00 read, 2'b01 write, 2'b10 load-linked, 2'b11 store-conditional. Every accepted request produces `*_rvalid` high for one cycle on the next clock. On that response, `*_rdata` carries the word held at the address before the operation.
- R2: Accepted writes from both ports to different addresses in the same cycle both update memory.
- R3: When both ports are valid with equal addresses, port A is accepted and `b_stall` is high in that cycle. Port B is not accepted, produces no response and must repeat its request.
- R4: A load-linked sets that port's reservation to valid with the request address. This replaces any earlier reservation of that port.
- R5: A store-conditional passes only if its port's reservation is valid and holds the same address. A passing store-conditional writes `wdata` and responds with `*_sc_ok` high.
- R6: Any store-conditional clears its port's reservation. A failing one responds with `*_sc_ok` low and leaves memory unchanged.
- R7: A write by the other port to a reserved address clears the reservation. This covers plain writes and passing store-conditionals. A failing store-conditional from the other port does not clear it.
- R8: When the two ports race for the same lock word with load-linked then store-conditional, exactly one store-conditional passes, and it is port A's.
- R9: After synchronous active-low reset, no response is valid, both reservations are invalid and every memory word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_valid | input | 1 | Port A request present |
| a_op | input | 2 | Port A operation code |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rvalid | output | 1 | Port A response valid |
| a_rdata | output | DW | Port A prior word value |
| a_sc_ok | output | 1 | Port A store-conditional passed |
| b_valid | input | 1 | Port B request present |
| b_op | input | 2 | Port B operation code |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_stall | output | 1 | Port B request not accepted this cycle |
| b_rvalid | output | 1 | Port B response valid |
| b_rdata | output | DW | Port B prior word value |
| b_sc_ok | output | 1 | Port B store-conditional passed |

## Verification
The assertions assume that a stalled port B keeps its request stable until it is accepted. They also assume that the address inputs are inside the memory depth. The stimulus re-presents every stalled port B request unchanged on the next cycle. It draws all addresses from the default sixteen-word range. It drives inputs only between clock edges, so the same-address check sees settled values.

// File: rtl/llsc_pkg.sv
// Package: shared operation encoding for the two-port synchronization unit.
// Assumes: both ports use the same two-bit operation code.
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_LL    = 2'b10,
        OP_SC    = 2'b11
    } op_e;
endpackage

// File: rtl/llsc_arb.sv
// Module: same-word arbiter. Port A always proceeds. Port B is held off
// whenever it targets the word port A is using in the same cycle.
// Assumes: a stalled port B holds its request until accepted.
module llsc_arb #(
    parameter int AW = 4
) (
    input  logic          a_valid,
    input  logic [AW-1:0] a_addr,
    input  logic          b_valid,
    input  logic [AW-1:0] b_addr,
    output logic          a_fire,
    output logic          b_fire,
    output logic          b_stall
);
    logic same_word;

    // Detect a same-address collision and grant port A priority.
    always_comb begin
        same_word = a_valid && b_valid && (a_addr == b_addr);
        a_fire    = a_valid;
        b_stall   = same_word;
        b_fire    = b_valid && !same_word;
    end
endmodule

// File: rtl/llsc_link.sv
// Module: one port's reservation (valid bit plus address). A load-linked
// sets it. Any store-conditional clears it. A write by the other port to
// the reserved word also clears it.
// Assumes: the arbiter never lets both ports act on one word in a cycle.
module llsc_link
    import llsc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  op_e           op,
    input  logic [AW-1:0] addr,
    input  logic          peer_wr,
    input  logic [AW-1:0] peer_addr,
    output logic          sc_pass,
    output logic          link_vld
);
    logic          vld_q;
    logic [AW-1:0] addr_q;
    logic          peer_hit;

    // Decide store-conditional outcome and detect a breaking peer write.
    always_comb begin
        sc_pass  = vld_q && (addr_q == addr);
        peer_hit = peer_wr && vld_q && (peer_addr == addr_q);
        link_vld = vld_q;
    end

    // Update the reservation: own ops first, then peer-write breakage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
        end else if (fire && op == OP_LL) begin
            vld_q  <= 1'b1;
            addr_q <= addr;
        end else if (fire && op == OP_SC) begin
            vld_q  <= 1'b0;
        end else if (peer_hit) begin
            vld_q  <= 1'b0;
        end
    end

    // R4: a load-linked leaves a valid link on the requested word
    a_r4_ll_sets_link: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_LL) |=> (link_vld && addr_q == $past(addr)));

    // R6: no link survives a store-conditional
    a_r6_sc_drops_link: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_SC) |=> !link_vld);

    // R7: a peer write to the linked word breaks the link
    a_r7_peer_breaks: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_wr && link_vld && peer_addr == addr_q && !(fire && op == OP_LL))
        |=> !link_vld);
endmodule

// File: rtl/llsc_mem.sv
// Module: dual-ported word memory model with registered read-before-write.
// Each port returns the word held before its own write in the same cycle.
// Assumes: the two ports never touch the same word in one cycle.
module llsc_mem #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          en,
    input  logic [1:0]          we,
    input  logic [1:0][AW-1:0]  addr,
    input  logic [1:0][DW-1:0]  wdata,
    output logic [1:0][DW-1:0]  rdata
);
    logic [DW-1:0] store [DEPTH];

    // Apply writes from both ports; clear the array on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (en[p] && we[p]) store[addr[p]] <= wdata[p];
            end
        end
    end

    // Capture the prior word for each port on an access.
    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n)      rdata[p] <= '0;
            else if (en[p])  rdata[p] <= store[addr[p]];
        end
    end

    // R3: the memory never sees two writes to one word in a cycle
    a_r3_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(en[0] && we[0] && en[1] && we[1] && addr[0] == addr[1]));
endmodule

// File: rtl/llsc_sync_unit.sv
// Module: top of the two-port load-linked / store-conditional unit.
// Joins the same-word arbiter, one reservation per port and the memory.
// It registers a response (prior word, store-conditional result) per port.
// Assumes: a stalled port B repeats its request unchanged.
module llsc_sync_unit
    import llsc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_valid,
    input  logic [1:0]    a_op,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic          a_rvalid,
    output logic [DW-1:0] a_rdata,
    output logic          a_sc_ok,
    input  logic          b_valid,
    input  logic [1:0]    b_op,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic          b_stall,
    output logic          b_rvalid,
    output logic [DW-1:0] b_rdata,
    output logic          b_sc_ok
);
    op_e                op_a, op_b;
    logic               a_fire, b_fire;
    logic               pass_a, pass_b;
    logic               link_a, link_b;
    logic               wr_a, wr_b;
    logic [1:0][DW-1:0] mem_rd;
    logic               rv_a_q, rv_b_q, ok_a_q, ok_b_q;

    // Cast the raw operation codes to the shared enum.
    always_comb begin
        op_a = op_e'(a_op);
        op_b = op_e'(b_op);
    end

    llsc_arb #(.AW(AW)) u_arb (
        .a_valid (a_valid),
        .a_addr  (a_addr),
        .b_valid (b_valid),
        .b_addr  (b_addr),
        .a_fire  (a_fire),
        .b_fire  (b_fire),
        .b_stall (b_stall)
    );

    // Form each port's memory write: plain writes and passing store-conditionals.
    always_comb begin
        wr_a = a_fire && (op_a == OP_WRITE || (op_a == OP_SC && pass_a));
        wr_b = b_fire && (op_b == OP_WRITE || (op_b == OP_SC && pass_b));
    end

    llsc_link #(.AW(AW)) u_link_a (
        .clk (clk), .rst_n (rst_n),
        .fire (a_fire), .op (op_a), .addr (a_addr),
        .peer_wr (wr_b), .peer_addr (b_addr),
        .sc_pass (pass_a), .link_vld (link_a)
    );

    llsc_link #(.AW(AW)) u_link_b (
        .clk (clk), .rst_n (rst_n),
        .fire (b_fire), .op (op_b), .addr (b_addr),
        .peer_wr (wr_a), .peer_addr (a_addr),
        .sc_pass (pass_b), .link_vld (link_b)
    );

    llsc_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .en    ({b_fire, a_fire}),
        .we    ({wr_b, wr_a}),
        .addr  ({b_addr, a_addr}),
        .wdata ({b_wdata, a_wdata}),
        .rdata (mem_rd)
    );

    // Register response valid and store-conditional result per port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_a_q <= 1'b0;
            rv_b_q <= 1'b0;
            ok_a_q <= 1'b0;
            ok_b_q <= 1'b0;
        end else begin
            rv_a_q <= a_fire;
            rv_b_q <= b_fire;
            ok_a_q <= a_fire && op_a == OP_SC && pass_a;
            ok_b_q <= b_fire && op_b == OP_SC && pass_b;
        end
    end

    assign a_rvalid = rv_a_q;
    assign b_rvalid = rv_b_q;
    assign a_sc_ok  = ok_a_q;
    assign b_sc_ok  = ok_b_q;
    assign a_rdata  = mem_rd[0];
    assign b_rdata  = mem_rd[1];

    // R3: the two ports are never accepted on one word together
    a_r3_no_twin_access: assert property (@(posedge clk) disable iff (!rst_n)
        (a_fire && b_fire) |-> (a_addr != b_addr));

    // R5: a passing result on port A requires a link the cycle before
    a_r5_a_pass_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rvalid && a_sc_ok) |-> $past(link_a));

    // R5: a passing result on port B requires a link the cycle before
    a_r5_b_pass_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rvalid && b_sc_ok) |-> $past(link_b));

    // R9: nothing responds in the first cycle after reset
    a_r9_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!a_rvalid && !b_rvalid));
endmodule

// File: tb/sim_llsc_sync_unit.sv
// Bench: scoreboard of expected responses per port, popped by a monitor.
module sim_llsc_sync_unit;
    localparam int DEPTH = 16;
    localparam int DW    = 32;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [1:0] RD = 2'b00, WR = 2'b01, LL = 2'b10, SC = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_valid = 1'b0, b_valid = 1'b0;
    logic [1:0]    a_op = RD, b_op = RD;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic          a_rvalid, b_rvalid, a_sc_ok, b_sc_ok, b_stall;
    logic [DW-1:0] a_rdata, b_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW:0] qa[$], qb[$];
    string       ta[$], tb_q[$];

    always #2 clk = ~clk;

    llsc_sync_unit #(.DEPTH(DEPTH), .DW(DW)) u0 (
        .clk (clk), .rst_n (rst_n),
        .a_valid (a_valid), .a_op (a_op), .a_addr (a_addr), .a_wdata (a_wdata),
        .a_rvalid (a_rvalid), .a_rdata (a_rdata), .a_sc_ok (a_sc_ok),
        .b_valid (b_valid), .b_op (b_op), .b_addr (b_addr), .b_wdata (b_wdata),
        .b_stall (b_stall),
        .b_rvalid (b_rvalid), .b_rdata (b_rdata), .b_sc_ok (b_sc_ok)
    );

    task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each response with the front of its port's queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (a_rvalid) begin
                if (qa.size() == 0) check("R1 unexpected A response", 1, 0);
                else check(ta.pop_front(), {a_sc_ok, a_rdata}, qa.pop_front());
            end
            if (b_rvalid) begin
                if (qb.size() == 0) check("R3 unexpected B response", 1, 0);
                else check(tb_q.pop_front(), {b_sc_ok, b_rdata}, qb.pop_front());
            end
        end
    end

    // Driver: present one cycle of requests and queue the expected responses.
    task automatic drive(
        input bit av, input logic [1:0] aop, input int aad, input logic [DW-1:0] awd,
        input logic [DW-1:0] aexp, input bit aok, input string atag,
        input bit bv, input logic [1:0] bop, input int bad, input logic [DW-1:0] bwd,
        input logic [DW-1:0] bexp, input bit bok, input string btag,
        input bit exp_stall);
        @(negedge clk);
        a_valid = av; a_op = aop; a_addr = AW'(aad); a_wdata = awd;
        b_valid = bv; b_op = bop; b_addr = AW'(bad); b_wdata = bwd;
        if (av) begin qa.push_back({aok, aexp}); ta.push_back(atag); end
        if (bv && !exp_stall) begin qb.push_back({bok, bexp}); tb_q.push_back(btag); end
        #1;
        if (bv) check({btag, " stall"}, {{DW{1'b0}}, b_stall}, {{DW{1'b0}}, exp_stall});
        @(posedge clk);
    endtask

    task automatic a_only(input logic [1:0] op, input int ad, input logic [DW-1:0] wd,
                          input logic [DW-1:0] exp, input bit ok, input string tag);
        drive(1, op, ad, wd, exp, ok, tag, 0, RD, 0, 0, 0, 0, "", 0);
    endtask

    task automatic b_only(input logic [1:0] op, input int ad, input logic [DW-1:0] wd,
                          input logic [DW-1:0] exp, input bit ok, input string tag);
        drive(0, RD, 0, 0, 0, 0, "", 1, op, ad, wd, exp, ok, tag, 0);
    endtask

    task automatic idle();
        @(negedge clk);
        a_valid = 0; b_valid = 0;
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 A rvalid in reset", {32'h0, a_rvalid}, 0);
        check("R9 B rvalid in reset", {32'h0, b_rvalid}, 0);
        rst_n = 1'b1;
        @(posedge clk);
        // R9: a word reads zero after reset
        a_only(RD, 4, 0, 32'h0, 0, "R9 memory zero");
        // R9: no reservation after reset
        b_only(SC, 4, 32'h5, 32'h0, 0, "R9 no link after reset");
        // R1/R2: two writes to different words in one cycle
        drive(1, WR, 3, 32'h11, 32'h0, 0, "R2 A write",
              1, WR, 5, 32'h22, 32'h0, 0, "R2 B write", 0);
        drive(1, RD, 5, 0, 32'h22, 0, "R1 A read",
              1, RD, 3, 0, 32'h11, 0, "R1 B read", 0);
        // R6: store-conditional without link fails, memory intact
        a_only(SC, 3, 32'h99, 32'h11, 0, "R6 unlinked sc");
        a_only(RD, 3, 0, 32'h11, 0, "R6 memory unchanged");
        // R4/R5: linked pair passes
        a_only(LL, 3, 0, 32'h11, 0, "R4 ll data");
        a_only(SC, 3, 32'h55, 32'h11, 1, "R5 linked sc");
        a_only(RD, 3, 0, 32'h55, 0, "R5 sc wrote");
        // R6: link consumed
        a_only(SC, 3, 32'h66, 32'h55, 0, "R6 second sc");
        a_only(RD, 3, 0, 32'h55, 0, "R6 second sc no write");
        // R7: peer plain write breaks the link
        a_only(LL, 7, 0, 32'h0, 0, "R4 ll word7");
        b_only(WR, 7, 32'h77, 32'h0, 0, "R7 peer write");
        a_only(SC, 7, 32'h88, 32'h77, 0, "R7 broken link");
        a_only(RD, 7, 0, 32'h77, 0, "R7 memory kept");
        // R5/R6: address mismatch fails and clears the link
        a_only(LL, 8, 0, 32'h0, 0, "R4 ll word8");
        a_only(SC, 9, 32'h9, 32'h0, 0, "R5 mismatched sc");
        a_only(SC, 8, 32'h8, 32'h0, 0, "R6 link gone");
        // R4: a new ll replaces the old link
        b_only(LL, 1, 0, 32'h0, 0, "R4 first ll");
        b_only(LL, 2, 0, 32'h0, 0, "R4 second ll");
        b_only(SC, 1, 32'h1, 32'h0, 0, "R4 old link replaced");
        // R3: same-word reads, A first, B stalled then served
        drive(1, RD, 5, 0, 32'h22, 0, "R3 A wins",
              1, RD, 5, 0, 32'h22, 0, "R3 B held", 1);
        b_only(RD, 5, 0, 32'h22, 0, "R3 B retried");
        // R8: lock race on word 10
        drive(1, LL, 10, 0, 32'h0, 0, "R8 A ll",
              1, LL, 10, 0, 32'h0, 0, "R8 B ll", 1);
        b_only(LL, 10, 0, 32'h0, 0, "R8 B ll retry");
        drive(1, SC, 10, 32'hA1, 32'h0, 1, "R8 A sc passes",
              1, SC, 10, 32'hB1, 32'h0, 0, "R8 B sc", 1);
        b_only(SC, 10, 32'hB1, 32'hA1, 0, "R8 B sc fails");
        a_only(RD, 10, 0, 32'hA1, 0, "R8 winner value");
        // R7: a failing peer sc does not break the link
        a_only(LL, 12, 0, 32'h0, 0, "R4 ll word12");
        b_only(SC, 12, 32'hBB, 32'h0, 0, "R7 failing peer sc");
        a_only(SC, 12, 32'hC, 32'h0, 1, "R7 link survived");
        // R2/R5: disjoint linked pairs pass together
        drive(1, LL, 1, 0, 32'h0, 0, "R4 A ll word1",
              1, LL, 2, 0, 32'h0, 0, "R4 B ll word2", 0);
        drive(1, SC, 1, 32'h1A, 32'h0, 1, "R5 A sc word1",
              1, SC, 2, 32'h2B, 32'h0, 1, "R5 B sc word2", 0);
        drive(1, RD, 2, 0, 32'h2B, 0, "R2 A reads word2",
              1, RD, 1, 0, 32'h1A, 0, "R2 B reads word1", 0);
        idle();
        idle();
        @(negedge clk);
        check("R1 no missing A response", {1'b0, 32'(qa.size())}, 0);
        check("R1 no missing B response", {1'b0, 32'(qb.size())}, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule